// File: doc/BRIEF.md
# Auxiliary-Channel Request Sequencer

This block carries one auxiliary-channel request from a host through to its result. The host presents a command type, a 20-bit target address, a byte count between 1 and 16 and up to 16 bytes of write data, then pulses `start`. The sequencer first waits for the channel engine to drop its busy indication. It then asks for ownership of the channel and waits for the grant. Next it confirms that a sink is attached, fills the outgoing byte buffer and launches the transfer through the engine.

An attempt whose reply status is not clean is retried. Before each attempt the engine receives a one-cycle reset pulse, and every attempt after the first waits a settling delay first. A read that completes cleanly hands the received bytes back, trimmed to the requested count. Ownership is dropped on every exit path. The result is reported as a 2-bit code together with a one-cycle `done` pulse.

All waits are measured in microseconds. A divider parameter converts clock cycles into microseconds, so a bench can shrink every delay without changing the sequencing.

Top module: `auxSeqTop`

## Requirements
- R1: While `lineBusy` stays high, the sequencer waits up to TIMEOUT_US microseconds. On expiry it finishes with status BUSY (code 1), without ever raising `ownReq` or `txGo`.
- R2: After the channel goes idle, `ownReq` rises. If `ownGrant` does not arrive within TIMEOUT_US microseconds, the request ends with status BUSY (code 1).
- R3: If `sinkPresent` is low once ownership is granted, the request ends with status NODEV (code 2) and no `txGo` is issued.
- R4: For a write (command type bit 0 = 0), `txWrData` byte i (bits 8i+7..8i) carries host byte i when i < size, and zero otherwise. For a read (type bit 0 = 1), `txWrData` is all zero when the request is issued.
- R5: During a request, `txCtrl` holds the command type in bits 15..12, size minus one in bits 3..0 and zero elsewhere. `txAddr` holds the host address.
- R6: At most MAX_TRIES attempts are made, and each one is preceded by a `txReset` pulse exactly one cycle long. If every attempt returns a nonzero `txStat`, the status is IOERR (code 3) and `txGo` has pulsed MAX_TRIES times.
- R7: The first `txGo` follows its `txReset` pulse by exactly 2 cycles. Every later `txGo` follows its own reset pulse by at least RETRY_DELAY_US microseconds.
- R8: If `txPending` stays high for TIMEOUT_US microseconds after `txGo`, the request ends with status IOERR (code 3) and no further attempt is made.
- R9: An attempt succeeds only when `txStat` is zero once pending clears; the result is then OK (code 0). On a successful read, `rdData` byte i equals `rxData` byte i for i < size and is zero above. On any other outcome, `rdData` is zero.
- R10: `ownReq` is low in the cycle `done` is high, whatever the outcome.
- R11: `done` is high for exactly one cycle per accepted `start`, and `status` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (accepted when idle) |
| cmdType | input | 4 | Command type; bit 0 set means read |
| cmdAddr | input | 20 | Target address |
| cmdSize | input | 5 | Byte count, 1 to 16 |
| cmdWrData | input | 128 | Write bytes, byte i in bits 8i+7..8i |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 BUSY, 2 NODEV, 3 IOERR |
| rdData | output | 128 | Read bytes returned to the host |
| lineBusy | input | 1 | Engine busy or pending flags |
| ownReq | output | 1 | Channel ownership request |
| ownGrant | input | 1 | Channel ownership grant |
| sinkPresent | input | 1 | Sink detected |
| txReset | output | 1 | Engine reset pulse before each attempt |
| txGo | output | 1 | Launch one attempt |
| txPending | input | 1 | Attempt in flight, self-clears |
| txStat | input | 8 | Reply and error bits, zero means clean |
| txCtrl | output | 16 | Control word: type and size minus one |
| txAddr | output | 20 | Address presented to the engine |
| txWrData | output | 128 | Outgoing byte buffer |
| rxData | input | 128 | Received byte buffer |

## Verification
The directed tests target the points where a sequencer like this tends to go wrong. One is the retry delay: a design that also delays the first attempt, or skips the delay on retries, gives a wrong reset-to-launch gap. Another is the attempt bound: an off-by-one shows up as 31 or 33 launches on a sink that never answers cleanly. Byte masking is checked in both directions, since a design that leaks bytes above the count corrupts the write buffer or the read result. The early exits (busy line, missing grant, missing sink, pending stuck high) are each checked for the right code, for no launch where none may occur, and for ownership being released.

// File: rtl/auxSeqPkg.sv
package auxSeqPkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_BUSY  = 2'd1,
    ST_NODEV = 2'd2,
    ST_IOERR = 2'd3
  } auxStat_e;

  // strobes from the sequencer control to the datapath and timer
  typedef struct packed {
    logic     clrTimer;
    logic     latchReq;
    logic     loadBuf;
    logic     captureRd;
    logic     setStat;
    auxStat_e statCode;
  } seqStrobe_t;

endpackage

// File: rtl/auxSeqTimer.sv
module auxSeqTimer #(
  parameter int CYC_PER_US = 250,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clr,
  output logic [US_W-1:0] usCnt
);
  localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);
  localparam logic [US_W-1:0]  US_MAX   = '1;

  logic [CYC_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else if (cycCnt == CYC_LAST) begin
      cycCnt <= '0;
      if (usCnt != US_MAX) usCnt <= usCnt + 1'b1;
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end
endmodule

// File: rtl/auxSeqDatapath.sv
module auxSeqDatapath
  import auxSeqPkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = 20,
  parameter int TYPE_W    = 4,
  parameter int CTRL_W    = 16,
  parameter int SIZE_W    = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strb,
  input  logic [TYPE_W-1:0]      cmdType,
  input  logic [ADDR_W-1:0]      cmdAddr,
  input  logic [SIZE_W-1:0]      cmdSize,
  input  logic [BUF_BYTES*8-1:0] cmdWrData,
  input  logic [BUF_BYTES*8-1:0] rxData,
  output logic                   isRead,
  output logic [1:0]             status,
  output logic [BUF_BYTES*8-1:0] rdData,
  output logic [CTRL_W-1:0]      txCtrl,
  output logic [ADDR_W-1:0]      txAddr,
  output logic [BUF_BYTES*8-1:0] txWrData
);
  localparam int DATA_W = BUF_BYTES * 8;
  localparam int CNT_W  = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
  localparam int PAD_W  = CTRL_W - TYPE_W - CNT_W;

  logic [TYPE_W-1:0] reqType;
  logic [SIZE_W-1:0] reqSize;
  logic [DATA_W-1:0] reqData;
  logic [DATA_W-1:0] byteMask;
  logic [CNT_W-1:0]  sizeM1;

  for (genvar g = 0; g < BUF_BYTES; g++) begin : gMask
    assign byteMask[g*8 +: 8] = {8{SIZE_W'(g) < reqSize}};
  end

  assign isRead = reqType[0];
  assign sizeM1 = CNT_W'(reqSize - SIZE_W'(1));
  assign txCtrl = {reqType, {PAD_W{1'b0}}, sizeM1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqType  <= '0;
      reqSize  <= SIZE_W'(1);
      reqData  <= '0;
      txAddr   <= '0;
      txWrData <= '0;
      rdData   <= '0;
      status   <= ST_OK;
    end else begin
      if (strb.latchReq) begin
        reqType  <= cmdType;
        reqSize  <= cmdSize;
        reqData  <= cmdWrData;
        txAddr   <= cmdAddr;
        txWrData <= '0;
        rdData   <= '0;
      end
      if (strb.loadBuf) txWrData <= isRead ? '0 : (reqData & byteMask);
      if (strb.captureRd) rdData <= rxData & byteMask;
      if (strb.setStat) status <= strb.statCode;
    end
  end
endmodule

// File: rtl/auxSeqCtrl.sv
module auxSeqCtrl
  import auxSeqPkg::*;
#(
  parameter int TIMEOUT_US     = 1000,
  parameter int RETRY_DELAY_US = 400,
  parameter int MAX_TRIES      = 32,
  parameter int US_W           = 10,
  parameter int STAT_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isRead,
  input  logic              lineBusy,
  input  logic              ownGrant,
  input  logic              sinkPresent,
  input  logic              txPending,
  input  logic [STAT_W-1:0] txStat,
  input  logic [US_W-1:0]   usCnt,
  output seqStrobe_t        strb,
  output logic              ownReq,
  output logic              txReset,
  output logic              txGo,
  output logic              done
);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TRY_W-1:0] TRY_LAST  = TRY_W'(MAX_TRIES - 1);
  localparam logic [US_W-1:0]  TOUT_LIM  = US_W'(TIMEOUT_US);
  localparam logic [US_W-1:0]  DELAY_LIM = US_W'(RETRY_DELAY_US);

  typedef enum logic [3:0] {
    S_IDLE, S_WAITIDLE, S_GRANT, S_SINK, S_LOAD, S_RSTON,
    S_RSTOFF, S_DELAY, S_ISSUE, S_PEND, S_EVAL, S_DONE
  } seqState_e;

  seqState_e st, nxt;
  logic [TRY_W-1:0] tryIdx;
  logic             tryInc, tryClr;

  always_comb begin
    nxt     = st;
    strb    = '0;
    txReset = 1'b0;
    txGo    = 1'b0;
    tryInc  = 1'b0;
    tryClr  = 1'b0;
    unique case (st)
      S_IDLE:
        if (start) begin
          strb.latchReq = 1'b1;
          nxt = S_WAITIDLE;
        end
      S_WAITIDLE:
        if (!lineBusy) nxt = S_GRANT;
        else if (usCnt >= TOUT_LIM) begin
          strb.setStat = 1'b1;
          strb.statCode = ST_BUSY;
          nxt = S_DONE;
        end
      S_GRANT:
        if (ownGrant) nxt = S_SINK;
        else if (usCnt >= TOUT_LIM) begin
          strb.setStat = 1'b1;
          strb.statCode = ST_BUSY;
          nxt = S_DONE;
        end
      S_SINK:
        if (!sinkPresent) begin
          strb.setStat = 1'b1;
          strb.statCode = ST_NODEV;
          nxt = S_DONE;
        end else nxt = S_LOAD;
      S_LOAD: begin
        strb.loadBuf = 1'b1;
        tryClr = 1'b1;
        nxt = S_RSTON;
      end
      S_RSTON: begin
        txReset = 1'b1;
        nxt = S_RSTOFF;
      end
      S_RSTOFF:
        nxt = (tryIdx != '0) ? S_DELAY : S_ISSUE;
      S_DELAY:
        if (usCnt >= DELAY_LIM) nxt = S_ISSUE;
      S_ISSUE: begin
        txGo = 1'b1;
        nxt = S_PEND;
      end
      S_PEND:
        if (!txPending) nxt = S_EVAL;
        else if (usCnt >= TOUT_LIM) begin
          strb.setStat = 1'b1;
          strb.statCode = ST_IOERR;
          nxt = S_DONE;
        end
      S_EVAL:
        if (txStat == '0) begin
          strb.setStat = 1'b1;
          strb.statCode = ST_OK;
          strb.captureRd = isRead;
          nxt = S_DONE;
        end else if (tryIdx == TRY_LAST) begin
          strb.setStat = 1'b1;
          strb.statCode = ST_IOERR;
          nxt = S_DONE;
        end else begin
          tryInc = 1'b1;
          nxt = S_RSTON;
        end
      S_DONE:
        nxt = S_IDLE;
      default:
        nxt = S_IDLE;
    endcase
    strb.clrTimer = (nxt != st);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= S_IDLE;
      tryIdx <= '0;
      ownReq <= 1'b0;
    end else begin
      st <= nxt;
      if (tryClr) tryIdx <= '0;
      else if (tryInc) tryIdx <= tryIdx + 1'b1;
      ownReq <= (nxt inside {S_GRANT, S_SINK, S_LOAD, S_RSTON, S_RSTOFF,
                             S_DELAY, S_ISSUE, S_PEND, S_EVAL});
    end
  end

  assign done = (st == S_DONE);
endmodule

// File: rtl/auxSeqTop.sv
module auxSeqTop
  import auxSeqPkg::*;
#(
  parameter int CYC_PER_US     = 250,
  parameter int TIMEOUT_US     = 1000,
  parameter int RETRY_DELAY_US = 400,
  parameter int MAX_TRIES      = 32,
  parameter int BUF_BYTES      = 16,
  parameter int ADDR_W         = 20,
  parameter int STAT_W         = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [3:0]             cmdType,
  input  logic [ADDR_W-1:0]      cmdAddr,
  input  logic [$clog2(BUF_BYTES+1)-1:0] cmdSize,
  input  logic [BUF_BYTES*8-1:0] cmdWrData,
  output logic                   done,
  output logic [1:0]             status,
  output logic [BUF_BYTES*8-1:0] rdData,
  input  logic                   lineBusy,
  output logic                   ownReq,
  input  logic                   ownGrant,
  input  logic                   sinkPresent,
  output logic                   txReset,
  output logic                   txGo,
  input  logic                   txPending,
  input  logic [STAT_W-1:0]      txStat,
  output logic [15:0]            txCtrl,
  output logic [ADDR_W-1:0]      txAddr,
  output logic [BUF_BYTES*8-1:0] txWrData,
  input  logic [BUF_BYTES*8-1:0] rxData
);
  localparam int SIZE_W = $clog2(BUF_BYTES + 1);
  localparam int US_MAXV = (TIMEOUT_US > RETRY_DELAY_US) ? TIMEOUT_US : RETRY_DELAY_US;
  localparam int US_W = $clog2(US_MAXV + 1);

  seqStrobe_t      strb;
  logic            isRead;
  logic [US_W-1:0] usCnt;

  auxSeqTimer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W)) timer_i (
    .clk(clk), .rstN(rstN), .clr(strb.clrTimer), .usCnt(usCnt)
  );

  auxSeqCtrl #(
    .TIMEOUT_US(TIMEOUT_US), .RETRY_DELAY_US(RETRY_DELAY_US),
    .MAX_TRIES(MAX_TRIES), .US_W(US_W), .STAT_W(STAT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .lineBusy(lineBusy), .ownGrant(ownGrant), .sinkPresent(sinkPresent),
    .txPending(txPending), .txStat(txStat), .usCnt(usCnt), .strb(strb),
    .ownReq(ownReq), .txReset(txReset), .txGo(txGo), .done(done)
  );

  auxSeqDatapath #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .TYPE_W(4), .CTRL_W(16),
    .SIZE_W(SIZE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdType(cmdType),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .cmdWrData(cmdWrData),
    .rxData(rxData), .isRead(isRead), .status(status), .rdData(rdData),
    .txCtrl(txCtrl), .txAddr(txAddr), .txWrData(txWrData)
  );
endmodule

// File: rtl/auxSeqChk.sv
module auxSeqChk #(
  parameter int MAX_TRIES = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic [1:0] status,
  input logic       ownReq,
  input logic       txReset,
  input logic       txGo
);
  logic [7:0] goCnt;

  always_ff @(posedge clk) begin
    if (!rstN || done) goCnt <= '0;
    else if (txGo && goCnt != 8'hFF) goCnt <= goCnt + 1'b1;
  end

  assert_busy_no_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'd1) |-> (goCnt == 0));

  assert_nodev_no_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'd2) |-> (goCnt == 0));

  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    txReset |=> !txReset);

  assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    txGo |-> (goCnt < 8'(MAX_TRIES)));

  assert_go_owned_R10: assert property (@(posedge clk) disable iff (!rstN)
    txGo |-> ownReq);

  assert_owner_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ownReq);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind auxSeqTop auxSeqChk #(.MAX_TRIES(MAX_TRIES)) chk_i (
  .clk(clk), .rstN(rstN), .done(done), .status(status),
  .ownReq(ownReq), .txReset(txReset), .txGo(txGo)
);

// File: tb/auxSeqTop_tb_top.sv
module auxSeqTop_tb_top;
  localparam int CYC  = 2;
  localparam int TOUT = 20;
  localparam int DLY  = 8;
  localparam int TRY  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic         start = 1'b0;
  logic [3:0]   cmdType = '0;
  logic [19:0]  cmdAddr = '0;
  logic [4:0]   cmdSize = 5'd1;
  logic [127:0] cmdWrData = '0;
  logic         done, ownReq, txReset, txGo;
  logic [1:0]   status;
  logic [127:0] rdData, txWrData;
  logic [15:0]  txCtrl;
  logic [19:0]  txAddr;
  logic         ownGrant, txPending;
  logic [7:0]   txStat;
  logic         lineBusy = 1'b0, sinkPresent = 1'b1;
  logic [127:0] rxData = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

  // stub controls
  bit grantEn = 1'b1;
  bit hang = 1'b0;
  int failCnt = 0;
  int attempt;
  int pendLeft;

  auxSeqTop #(.CYC_PER_US(CYC), .TIMEOUT_US(TOUT), .RETRY_DELAY_US(DLY),
              .MAX_TRIES(TRY)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdType(cmdType),
    .cmdAddr(cmdAddr), .cmdSize(cmdSize), .cmdWrData(cmdWrData),
    .done(done), .status(status), .rdData(rdData), .lineBusy(lineBusy),
    .ownReq(ownReq), .ownGrant(ownGrant), .sinkPresent(sinkPresent),
    .txReset(txReset), .txGo(txGo), .txPending(txPending), .txStat(txStat),
    .txCtrl(txCtrl), .txAddr(txAddr), .txWrData(txWrData), .rxData(rxData)
  );

  // behavioural channel engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownGrant <= 1'b0; txPending <= 1'b0; txStat <= '0;
      attempt <= 0; pendLeft <= 0;
    end else begin
      ownGrant <= ownReq & grantEn;
      if (start) attempt <= 0;
      if (txGo) begin
        txPending <= 1'b1;
        pendLeft <= 3;
        txStat <= (attempt < failCnt) ? 8'h04 : 8'h00;
        attempt <= attempt + 1;
      end else if (txPending && !hang) begin
        if (pendLeft == 0) txPending <= 1'b0;
        else pendLeft <= pendLeft - 1;
      end
    end
  end

  // observation at the falling edge
  int cyc = 0, goCnt = 0, lastRst = 0, gap0 = 0, minGap = 0;
  bit ownSeen = 1'b0;
  logic [15:0]  goCtrl;
  logic [19:0]  goAddr;
  logic [127:0] goWr;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (ownReq) ownSeen = 1'b1;
    if (txReset) lastRst = cyc;
    if (txGo) begin
      if (goCnt == 0) gap0 = cyc - lastRst;
      else if (minGap == 0 || cyc - lastRst < minGap) minGap = cyc - lastRst;
      goCnt = goCnt + 1;
      goCtrl = txCtrl; goAddr = txAddr; goWr = txWrData;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] keep(input logic [127:0] d, input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) if (i < n) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  logic [1:0]   resStat;
  logic [127:0] resRd;
  bit           ownAtDone;

  task automatic runTxn(input logic [3:0] t, input logic [19:0] a,
                        input int n, input logic [127:0] d);
    goCnt = 0; gap0 = 0; minGap = 0; ownSeen = 1'b0;
    @(negedge clk);
    cmdType = t; cmdAddr = a; cmdSize = 5'(n); cmdWrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    resStat = status; resRd = rdData; ownAtDone = ownReq;
    @(negedge clk);
    chk(!done, "R11 done single cycle", 128'(done), 128'd0);
  endtask

  task automatic tReset();
    chk(!done && !ownReq && !txGo && !txReset, "R11 reset outputs idle",
        {124'd0, done, ownReq, txGo, txReset}, 128'd0);
    chk(rdData == '0 && status == 2'd0, "R9 reset rdData/status",
        rdData, 128'd0);
  endtask

  task automatic tWrite();
    logic [127:0] d = 128'h11223344_55667788_99AABBCC_DDEEFF00;
    runTxn(4'h8, 20'h00_1A2, 5, d);
    chk(resStat == 2'd0, "R9 write ok", 128'(resStat), 128'd0);
    chk(goCnt == 1, "R6 single attempt", 128'(goCnt), 128'd1);
    chk(goWr == keep(d, 5), "R4 write buffer masked", goWr, keep(d, 5));
    chk(goCtrl == 16'h8004, "R5 control word", 128'(goCtrl), 128'h8004);
    chk(goAddr == 20'h001A2, "R5 address", 128'(goAddr), 128'h1A2);
    chk(gap0 == 2, "R7 first attempt no delay", 128'(gap0), 128'd2);
    chk(!ownAtDone, "R10 released after ok", 128'(ownAtDone), 128'd0);
    chk(resRd == '0, "R9 write returns no read data", resRd, 128'd0);
  endtask

  task automatic tWriteFull();
    logic [127:0] d = 128'hCAFEBABE_DEADBEEF_01234567_89ABCDEF;
    runTxn(4'h4, 20'hFFFFF, 16, d);
    chk(goWr == d, "R4 full write buffer", goWr, d);
    chk(goCtrl == 16'h400F, "R5 control word full size", 128'(goCtrl), 128'h400F);
  endtask

  task automatic tRead();
    runTxn(4'h9, 20'h00200, 7, 128'hFFFF);
    chk(resStat == 2'd0, "R9 read ok", 128'(resStat), 128'd0);
    chk(resRd == keep(rxData, 7), "R9 read data masked", resRd, keep(rxData, 7));
    chk(goWr == '0, "R4 read leaves buffer zero", goWr, 128'd0);
    chk(goCtrl == 16'h9006, "R5 read control word", 128'(goCtrl), 128'h9006);
  endtask

  task automatic tLineBusy();
    lineBusy = 1'b1;
    runTxn(4'h8, 20'h1, 1, 128'h5);
    lineBusy = 1'b0;
    chk(resStat == 2'd1, "R1 busy status", 128'(resStat), 128'd1);
    chk(!ownSeen && goCnt == 0, "R1 no ownership or request",
        128'({ownSeen, 8'(goCnt)}), 128'd0);
  endtask

  task automatic tNoGrant();
    grantEn = 1'b0;
    runTxn(4'h8, 20'h1, 1, 128'h5);
    grantEn = 1'b1;
    chk(resStat == 2'd1, "R2 grant timeout busy", 128'(resStat), 128'd1);
    chk(ownSeen, "R2 ownership requested", 128'(ownSeen), 128'd1);
    chk(!ownAtDone && goCnt == 0, "R10 released after grant timeout",
        128'({ownAtDone, 8'(goCnt)}), 128'd0);
  endtask

  task automatic tNoSink();
    sinkPresent = 1'b0;
    runTxn(4'h9, 20'h1, 4, 128'h0);
    sinkPresent = 1'b1;
    chk(resStat == 2'd2, "R3 nodev status", 128'(resStat), 128'd2);
    chk(goCnt == 0, "R3 no request issued", 128'(goCnt), 128'd0);
    chk(!ownAtDone, "R10 released after nodev", 128'(ownAtDone), 128'd0);
  endtask

  task automatic tRetryOk();
    failCnt = 2;
    runTxn(4'h9, 20'h3, 3, 128'h0);
    failCnt = 0;
    chk(resStat == 2'd0, "R9 ok after retries", 128'(resStat), 128'd0);
    chk(goCnt == 3, "R6 three attempts", 128'(goCnt), 128'd3);
    chk(gap0 == 2, "R7 first gap", 128'(gap0), 128'd2);
    chk(minGap >= DLY * CYC, "R7 retry delay", 128'(minGap), 128'(DLY * CYC));
    chk(resRd == keep(rxData, 3), "R9 read data after retry",
        resRd, keep(rxData, 3));
  endtask

  task automatic tAllFail();
    failCnt = 1000;
    runTxn(4'h9, 20'h4, 2, 128'h0);
    failCnt = 0;
    chk(resStat == 2'd3, "R6 ioerr after all tries", 128'(resStat), 128'd3);
    chk(goCnt == TRY, "R6 attempt count", 128'(goCnt), 128'(TRY));
    chk(resRd == '0, "R9 failed read returns zero", resRd, 128'd0);
    chk(!ownAtDone, "R10 released after ioerr", 128'(ownAtDone), 128'd0);
  endtask

  task automatic tHang();
    hang = 1'b1;
    runTxn(4'h8, 20'h5, 1, 128'h7);
    hang = 1'b0;
    chk(resStat == 2'd3, "R8 pending timeout ioerr", 128'(resStat), 128'd3);
    chk(goCnt == 1, "R8 no retry after timeout", 128'(goCnt), 128'd1);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite();
    tWriteFull();
    tRead();
    tLineBusy();
    tNoGrant();
    tNoSink();
    tRetryOk();
    tAllFail();
    tHang();
    tRead();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule